// File: doc/BRIEF.md
# Frame-Synchronous Capture Controller

This block sits between a camera front end and the write path that stores pixels. It lets pixels through only for whole frames. Software asks for one of two kinds of capture. A one-cycle request asks for a single still frame. A level enable asks for continuous video. The block holds either kind back until a frame boundary. Capture starts at the first frame start that follows the request. It stops only after the last pixel of the frame in progress.

The front end supplies four strobes: field start, field end, field identity and pixel valid. In interlaced frame-planar 4:2:0 mode a frame spans two fields. In that mode a frame opens only at a field start that carries field identity 0. It closes only at the end of field 1. In every other mode each field start opens a frame and each field end closes one.

Software reads a status word that shows the two busy flags and the most recently started field. Each capture kind also has a done pulse that marks the cycle its busy flag drops.

Top module: `frame_cap_ctrl`

## Requirements
- R1: After a synchronous reset (`rst_ni` low at a clock edge), `cap_status_o` is 0, `pix_gate_o` is 0 and both done outputs are 0. This also holds when reset arrives during a capture.
- R2: The still busy flag (`cap_status_o[0]`) rises one cycle after the first frame start that comes strictly after the cycle of the `still_req_i` pulse. A request made in the middle of a frame waits for the next frame start.
- R3: While the still busy flag is set, a frame end clears it on the next cycle. In that same cycle `still_done_o` is 1.
- R4: With `video_en_i` high, the video busy flag (`cap_status_o[1]`) rises one cycle after the next frame start. It stays set across later frame ends while the enable stays high.
- R5: If `video_en_i` drops while video is busy, the flag stays set until the frame end of the current frame. On the cycle after that frame end the flag is 0 and `video_done_o` is 1.
- R6: With `planar420_i` = 1, only a field start with `field_id_i` = 0 counts as a frame start, and only a field end inside field 1 counts as a frame end. A field end inside field 0 leaves capture running.
- R7: With `planar420_i` = 0, every field end counts as a frame end, whatever the field identity.
- R8: `cap_status_o[2]` takes the value of `field_id_i` sampled at each field start (0 means field 0, 1 means field 1). Bits 31 down to 3 are always 0.
- R9: `pix_gate_o` equals `pix_vld_i` AND (either busy flag) AND (a field is open). A field is open from the cycle after its start strobe through the cycle of its end strobe.
- R10: A `still_req_i` pulse that arrives while the video busy flag is set is ignored. No still capture follows, even after video stops.
- R11: Each done output is high for exactly one cycle per completed capture.
- R12: If `video_en_i` is withdrawn before any frame start occurs, no video capture takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| still_req_i | input | 1 | One-cycle request for a single-frame capture |
| video_en_i | input | 1 | Level enable for continuous capture |
| fs_i | input | 1 | Field start strobe |
| fe_i | input | 1 | Field end strobe |
| field_id_i | input | 1 | Field identity, valid with `fs_i` |
| pix_vld_i | input | 1 | Pixel valid from the front end |
| planar420_i | input | 1 | 1 selects interlaced frame-planar 4:2:0 framing |
| pix_gate_o | output | 1 | Qualified pixel valid toward the write path |
| cap_status_o | output | STATUS_W | Status: bit0 still busy, bit1 video busy, bit2 field |
| still_done_o | output | 1 | One-cycle pulse when a still capture ends |
| video_done_o | output | 1 | One-cycle pulse when a video capture ends |

## Verification
The hardest case to reach is a still request that is silently dropped because video is running. The drop only shows later, so the stimulus has to carry on past it. The bench starts video and waits for its busy flag. It then pulses the still request inside a running frame, withdraws the video enable and lets that frame close. Finally it opens one more frame and confirms that the still flag never rises.

Interlaced framing needs a similar multi-step sequence. A field-0 end has to be seen to leave capture running before a field-1 start and a field-1 end finish it.

// File: rtl/fcc_pkg.sv
`timescale 1ns/1ps
package fcc_pkg;

    typedef enum logic [1:0] {
        CAP_IDLE  = 2'd0,
        CAP_ARMED = 2'd1,
        CAP_BUSY  = 2'd2
    } cap_state_e;

    typedef struct packed {
        cap_state_e st;
        logic       done;
    } cap_fsm_s;

    typedef struct packed {
        logic active;
        logic field;
    } trk_s;

    localparam int unsigned ST_STILL_BIT = 0;
    localparam int unsigned ST_VIDEO_BIT = 1;
    localparam int unsigned ST_FIELD_BIT = 2;
    localparam int unsigned ST_USED_W    = 3;

endpackage

// File: rtl/fcc_frame_track.sv
`timescale 1ns/1ps
module fcc_frame_track
    import fcc_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic fs_i,
    input  logic fe_i,
    input  logic field_id_i,
    input  logic planar_i,
    output logic frame_start_o,
    output logic frame_end_o,
    output logic field_o,
    output logic active_o
);
    trk_s trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (fe_i) begin
            trk_d.active = 1'b0;
        end
        if (fs_i) begin
            trk_d.active = 1'b1;
            trk_d.field  = field_id_i;
        end
        // interlaced planar: the frame opens on field 0, closes after field 1
        frame_start_o = fs_i && (!planar_i || !field_id_i);
        frame_end_o   = fe_i && (!planar_i || trk_q.field);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign field_o  = trk_q.field;
    assign active_o = trk_q.active;

    p_field_latch_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fs_i |=> (field_o == $past(field_id_i)));

    p_open_after_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fs_i |=> active_o);

endmodule

// File: rtl/fcc_still_fsm.sv
`timescale 1ns/1ps
module fcc_still_fsm
    import fcc_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_i,
    input  logic video_busy_i,
    input  logic frame_start_i,
    input  logic frame_end_i,
    output logic busy_o,
    output logic done_o
);
    cap_fsm_s fsm_d, fsm_q;

    always_comb begin
        fsm_d      = fsm_q;
        fsm_d.done = 1'b0;
        unique case (fsm_q.st)
            CAP_IDLE: begin
                if (req_i && !video_busy_i) begin
                    fsm_d.st = CAP_ARMED;
                end
            end
            CAP_ARMED: begin
                if (frame_start_i) begin
                    fsm_d.st = CAP_BUSY;
                end
            end
            CAP_BUSY: begin
                if (frame_end_i) begin
                    fsm_d.st   = CAP_IDLE;
                    fsm_d.done = 1'b1;
                end
            end
            default: fsm_d.st = CAP_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            fsm_q <= '{st: CAP_IDLE, done: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign busy_o = (fsm_q.st == CAP_BUSY);
    assign done_o = fsm_q.done;

    p_arm_to_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsm_q.st == CAP_ARMED && frame_start_i) |=> busy_o);

    p_end_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && frame_end_i) |=> (!busy_o && done_o));

    p_ignore_in_video_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsm_q.st == CAP_IDLE && video_busy_i) |=> (fsm_q.st == CAP_IDLE));

    p_done_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

endmodule

// File: rtl/fcc_video_fsm.sv
`timescale 1ns/1ps
module fcc_video_fsm
    import fcc_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic frame_start_i,
    input  logic frame_end_i,
    output logic busy_o,
    output logic done_o
);
    cap_fsm_s fsm_d, fsm_q;

    always_comb begin
        fsm_d      = fsm_q;
        fsm_d.done = 1'b0;
        unique case (fsm_q.st)
            CAP_IDLE: begin
                if (en_i) begin
                    fsm_d.st = CAP_ARMED;
                end
            end
            CAP_ARMED: begin
                if (!en_i) begin
                    fsm_d.st = CAP_IDLE;
                end else if (frame_start_i) begin
                    fsm_d.st = CAP_BUSY;
                end
            end
            CAP_BUSY: begin
                if (!en_i && frame_end_i) begin
                    fsm_d.st   = CAP_IDLE;
                    fsm_d.done = 1'b1;
                end
            end
            default: fsm_d.st = CAP_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            fsm_q <= '{st: CAP_IDLE, done: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign busy_o = (fsm_q.st == CAP_BUSY);
    assign done_o = fsm_q.done;

    p_enabled_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsm_q.st == CAP_ARMED && en_i && frame_start_i) |=> busy_o);

    p_hold_to_frame_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !frame_end_i) |=> busy_o);

    p_withdrawn_no_busy_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && !en_i) |=> !busy_o);

    p_done_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

endmodule

// File: rtl/frame_cap_ctrl.sv
`timescale 1ns/1ps
module frame_cap_ctrl
    import fcc_pkg::*;
#(
    parameter int unsigned STATUS_W = 32
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                still_req_i,
    input  logic                video_en_i,
    input  logic                fs_i,
    input  logic                fe_i,
    input  logic                field_id_i,
    input  logic                pix_vld_i,
    input  logic                planar420_i,
    output logic                pix_gate_o,
    output logic [STATUS_W-1:0] cap_status_o,
    output logic                still_done_o,
    output logic                video_done_o
);
    localparam int unsigned PAD_W = STATUS_W - ST_USED_W;

    logic frame_start, frame_end, field_cur, field_open;
    logic still_busy, video_busy;

    fcc_frame_track u_track (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .fs_i          (fs_i),
        .fe_i          (fe_i),
        .field_id_i    (field_id_i),
        .planar_i      (planar420_i),
        .frame_start_o (frame_start),
        .frame_end_o   (frame_end),
        .field_o       (field_cur),
        .active_o      (field_open)
    );

    fcc_still_fsm u_still (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .req_i         (still_req_i),
        .video_busy_i  (video_busy),
        .frame_start_i (frame_start),
        .frame_end_i   (frame_end),
        .busy_o        (still_busy),
        .done_o        (still_done_o)
    );

    fcc_video_fsm u_video (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .en_i          (video_en_i),
        .frame_start_i (frame_start),
        .frame_end_i   (frame_end),
        .busy_o        (video_busy),
        .done_o        (video_done_o)
    );

    always_comb begin
        cap_status_o               = '0;
        cap_status_o[ST_STILL_BIT] = still_busy;
        cap_status_o[ST_VIDEO_BIT] = video_busy;
        cap_status_o[ST_FIELD_BIT] = field_cur;
        pix_gate_o = pix_vld_i && field_open && (still_busy || video_busy);
    end

    p_gate_needs_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pix_gate_o |-> (pix_vld_i && cap_status_o[1:0] != 2'b00));

    p_field0_end_keeps_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (planar420_i && fe_i && !fs_i && !cap_status_o[ST_FIELD_BIT]
         && cap_status_o[ST_STILL_BIT]) |=> cap_status_o[ST_STILL_BIT]);

    p_upper_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cap_status_o[STATUS_W-1:ST_USED_W] == {PAD_W{1'b0}});

    p_reset_clears_r1: assert property (@(posedge clk_i)
        !rst_ni |=> (cap_status_o == '0 && !still_done_o && !video_done_o));

endmodule

// File: tb/frame_cap_ctrl_tb_top.sv
`timescale 1ns/1ps
module frame_cap_ctrl_tb_top;
    localparam int unsigned SW = 32;

    logic clk = 1'b0;
    logic rst_n, still_req, video_en, fs, fe, fid, pvld, planar;
    logic pgate, sdone, vdone;
    logic [SW-1:0] status;
    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    frame_cap_ctrl #(.STATUS_W(SW)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .still_req_i(still_req), .video_en_i(video_en),
        .fs_i(fs), .fe_i(fe), .field_id_i(fid), .pix_vld_i(pvld), .planar420_i(planar),
        .pix_gate_o(pgate), .cap_status_o(status), .still_done_o(sdone), .video_done_o(vdone)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // inputs change at negedge; one call = one rising edge, outputs then settled
    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic field_start(input logic id);
        fs = 1'b1; fid = id; cyc(); fs = 1'b0;
    endtask

    task automatic field_end();
        fe = 1'b1; cyc(); fe = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cyc(); cyc(); rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 status", status, 32'h0);
        check("R1 dones", {30'd0, sdone, vdone}, 32'h0);
        pvld = 1'b1; #1;
        check("R1 gate", {31'd0, pgate}, 32'h0);
        pvld = 1'b0;
    endtask

    task automatic t_still_basic();
        planar = 1'b0;
        still_req = 1'b1; cyc(); still_req = 1'b0;
        check("R2 armed not busy", {31'd0, status[0]}, 32'h0);
        field_start(1'b1);
        check("R2 busy after start", {31'd0, status[0]}, 32'h1);
        check("R8 field bit", status, 32'h5);
        pvld = 1'b1; #1;
        check("R9 gate open", {31'd0, pgate}, 32'h1);
        pvld = 1'b0; #1;
        check("R9 gate no valid", {31'd0, pgate}, 32'h0);
        cyc();
        field_end();
        check("R7 field end closes", {31'd0, status[0]}, 32'h0);
        check("R3 still done", {31'd0, sdone}, 32'h1);
        cyc();
        check("R11 done one cycle", {31'd0, sdone}, 32'h0);
    endtask

    task automatic t_still_midframe();
        field_start(1'b0);
        check("R8 field zero", status, 32'h0);
        still_req = 1'b1; cyc(); still_req = 1'b0;
        cyc();
        check("R2 midframe waits", {31'd0, status[0]}, 32'h0);
        field_end();
        check("R2 still idle at end", {31'd0, status[0]}, 32'h0);
        pvld = 1'b1; #1;
        check("R9 gate closed idle", {31'd0, pgate}, 32'h0);
        pvld = 1'b0;
        field_start(1'b0);
        check("R2 busy next frame", {31'd0, status[0]}, 32'h1);
        field_end();
        check("R3 done midframe case", {31'd0, sdone}, 32'h1);
    endtask

    task automatic t_planar();
        planar = 1'b1;
        still_req = 1'b1; cyc(); still_req = 1'b0;
        field_start(1'b1);
        check("R6 field1 start not frame", {31'd0, status[0]}, 32'h0);
        field_end();
        field_start(1'b0);
        check("R6 busy on field0", {31'd0, status[0]}, 32'h1);
        field_end();
        check("R6 field0 end keeps", {31'd0, status[0]}, 32'h1);
        check("R6 no done yet", {31'd0, sdone}, 32'h0);
        pvld = 1'b1; #1;
        check("R9 gate between fields", {31'd0, pgate}, 32'h0);
        pvld = 1'b0;
        field_start(1'b1);
        check("R8 field1 latched", status, 32'h5);
        field_end();
        check("R6 field1 end clears", {31'd0, status[0]}, 32'h0);
        check("R6 done at field2 end", {31'd0, sdone}, 32'h1);
        planar = 1'b0;
    endtask

    task automatic t_video();
        field_start(1'b0);
        video_en = 1'b1; cyc();
        check("R4 not busy midframe", {31'd0, status[1]}, 32'h0);
        field_end();
        field_start(1'b1);
        check("R4 busy at start", {31'd0, status[1]}, 32'h1);
        field_end();
        check("R4 stays across end", {31'd0, status[1]}, 32'h1);
        check("R11 no video done", {31'd0, vdone}, 32'h0);
        field_start(1'b0);
        video_en = 1'b0; cyc();
        check("R5 held after disable", {31'd0, status[1]}, 32'h1);
        field_end();
        check("R5 cleared at end", {31'd0, status[1]}, 32'h0);
        check("R5 video done", {31'd0, vdone}, 32'h1);
        cyc();
        check("R11 video done once", {31'd0, vdone}, 32'h0);
    endtask

    task automatic t_still_in_video();
        video_en = 1'b1; cyc();
        field_start(1'b0);
        check("R10 video busy", {31'd0, status[1]}, 32'h1);
        still_req = 1'b1; cyc(); still_req = 1'b0;
        video_en = 1'b0;
        field_end();
        check("R10 video ended", {31'd0, status[1]}, 32'h0);
        field_start(1'b0);
        check("R10 still ignored", {31'd0, status[0]}, 32'h0);
        field_end();
    endtask

    task automatic t_video_cancel();
        video_en = 1'b1; cyc(); cyc();
        video_en = 1'b0; cyc();
        field_start(1'b0);
        check("R12 withdrawn no capture", {31'd0, status[1]}, 32'h0);
        field_end();
    endtask

    task automatic t_reset_mid();
        still_req = 1'b1; cyc(); still_req = 1'b0;
        field_start(1'b1);
        check("R1 busy before reset", {31'd0, status[0]}, 32'h1);
        do_reset();
        check("R1 reset mid capture", status, 32'h0);
        field_end();
        check("R1 no done after reset", {31'd0, sdone}, 32'h0);
    endtask

    initial begin
        #(8 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; still_req = 1'b0; video_en = 1'b0; fs = 1'b0; fe = 1'b0;
        fid = 1'b0; pvld = 1'b0; planar = 1'b0;
        t_reset();
        t_still_basic();
        t_still_midframe();
        t_planar();
        t_video();
        t_still_in_video();
        t_video_cancel();
        t_reset_mid();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule